// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Thresholds

This block is a first-in first-out buffer for 18-bit words whose producer and consumer run on unrelated clocks. Neither clock has to be the faster one and no input says which is. The producer pushes words on the write clock and the consumer takes them on the read clock. Both sides may be active in the same cycle. Pointers cross between the two domains as Gray codes through two-flop synchronizers. Each side therefore computes its own flags from a slightly old copy of the other side's pointer. A flag may clear a few cycles late but never early.

Five status outputs are provided: full, half-full and almost-full on the write side, and empty and almost-empty on the read side. The two almost thresholds are programmable. At master reset each threshold takes one of two preset values, picked by a configuration input. Later they can be rewritten either as two parallel words on the data bus or serially one bit per write clock. The same serial pin selects the output timing when master reset is held. In standard timing a read request is needed to present each word. In fall-through timing the oldest word appears at the output by itself. A partial reset empties the buffer and keeps the thresholds and the timing. A retransmit input replays from the first stored word. An output enable gates the data bus, modelled as a zeroed bus plus a drive-enable output.

Top module: `dcff_top`

## Requirements
- R1: While master reset is held and after its release, rd_empty is 1, wr_full is 0, half_full is 0, almost_full is 0 and almost_empty is 1.
- R2: At master reset, si_mode is sampled: 0 gives standard timing, 1 gives fall-through timing. dflt_sel is also sampled: 0 sets both thresholds to OFS_LO and 1 sets both to OFS_HI. A master reset discards any threshold programmed before it.
- R3: wr_full rises immediately after the 2**ADDR_W-th unread write. A write attempted while wr_full is 1 stores nothing, and only the earlier words are read back.
- R4: In standard timing, ren with rd_empty at 0 takes the oldest word, and dout shows it after that read clock edge. ren while rd_empty is 1 changes neither dout nor the read position. After a write into an empty buffer, rd_empty falls within four read clocks.
- R5: half_full is 1 exactly when the write-side count of unread words exceeds 2**ADDR_W/2.
- R6: almost_full is 1 when the write-side count is at least 2**ADDR_W minus the full threshold. almost_empty is 1 when the read-side count of readable words is at most the empty threshold.
- R7: With ld at 1, wen stores din[ADDR_W-1:0] into the empty threshold first and into the full threshold on the next such write, and no data is stored. With ld and sen at 1, si_mode shifts in one bit per write clock: the empty threshold gets its LSB first, and its bits are followed by those of the full threshold.
- R8: Partial reset empties the buffer (rd_empty 1, wr_full 0, half_full 0) and keeps both thresholds and the timing mode.
- R9: A one-cycle pulse on rt returns the read position to the first word stored since the last reset. The same words are then delivered again in order; in fall-through timing the first of them reappears without a read request.
- R10: In fall-through timing, rd_empty is 0 exactly while a word is shown on dout. The first word written appears within four read clocks with no read request, and each ren with rd_empty at 0 removes the shown word.
- R11: With oe at 0, dout is all zero and dout_drv is 0. Raising oe again shows the held word unchanged.
- R12: Under any ratio of the two clocks, in either timing, every written word is read exactly once and in write order, after which rd_empty is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| mrst | input | 1 | Master reset, synchronous, active high, held for several cycles of both clocks |
| prst | input | 1 | Partial reset, clears data only |
| si_mode | input | 1 | Serial threshold bit; timing select while mrst is held |
| dflt_sel | input | 1 | Default threshold choice sampled at master reset |
| ld | input | 1 | Threshold load qualifier |
| sen | input | 1 | Serial load enable |
| wen | input | 1 | Write enable |
| din | input | 18 | Write data, or parallel threshold value |
| ren | input | 1 | Read enable |
| rt | input | 1 | Retransmit request (read clock) |
| oe | input | 1 | Output enable |
| dout | output | 18 | Read data, zero when oe is low |
| dout_drv | output | 1 | High when the data bus is driven |
| rd_empty | output | 1 | No word can be read (empty or not ready) |
| wr_full | output | 1 | No word can be written |
| half_full | output | 1 | More than half the entries in use |
| almost_empty | output | 1 | Readable count at or below the empty threshold |
| almost_full | output | 1 | Count at or above depth minus the full threshold |

## Verification
A wrong pointer or synchronizer value shows first as a wrong flag. That is a full that rises one word early or late, an almost threshold off by one, or rd_empty failing to fall within four read clocks. A word lost, duplicated or reordered inside the buffer shows at dout as soon as that word is read, and the streaming runs compare each word as it arrives. A threshold register that drifted or was cleared by partial reset shows as almost flags that switch at the wrong count. A wrong mode shows as a word that fails to appear without a read request.

// File: rtl/dcff_pkg.sv
package dcff_pkg;

    localparam int DATA_W = 18;

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic {
        TIMING_STD  = 1'b0,
        TIMING_FWFT = 1'b1
    } timing_e;

    typedef struct packed {
        logic full;
        logic almost_full;
        logic half_full;
    } wr_status_t;

    typedef struct packed {
        logic empty;
        logic almost_empty;
    } rd_status_t;

endpackage

// File: rtl/dcff_g2b.sv
module dcff_g2b #(
    parameter int W = 5
) (
    input  logic [W-1:0] gray,
    output logic [W-1:0] bin
);
    always_comb begin
        logic [W-1:0] acc;
        acc[W-1] = gray[W-1];
        for (int i = W - 2; i >= 0; i--) begin
            acc[i] = acc[i+1] ^ gray[i];
        end
        bin = acc;
    end
endmodule

// File: rtl/dcff_sync.sv
module dcff_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/dcff_ram.sv
module dcff_ram
    import dcff_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  word_t             wdata,
    input  logic [ADDR_W-1:0] raddr,
    output word_t             rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    word_t store [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/dcff_wr.sv
module dcff_wr
    import dcff_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int OFS_LO = 7,
    parameter int OFS_HI = 31
) (
    input  logic              clk,
    input  logic              mrst,
    input  logic              prst,
    input  logic              wen,
    input  logic              ld,
    input  logic              sen,
    input  logic              si,
    input  logic              dflt_sel,
    input  logic [ADDR_W-1:0] ofs_din,
    input  logic [ADDR_W:0]   rgray_s,
    output logic              we,
    output logic [ADDR_W-1:0] waddr,
    output logic [ADDR_W:0]   wgray,
    output wr_status_t        st,
    output logic [ADDR_W-1:0] ae_ofs,
    output logic [ADDR_W-1:0] af_ofs,
    output timing_e           mode
);
    localparam int PW = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);
    localparam logic [PW-1:0] HALF_CNT = PW'(DEPTH / 2);
    localparam logic [ADDR_W-1:0] LO_V = ADDR_W'(OFS_LO);
    localparam logic [ADDR_W-1:0] HI_V = ADDR_W'(OFS_HI);

    logic              rst;
    logic [PW-1:0]     wbin, wnext, rbin_s, wcnt;
    logic [2*ADDR_W-1:0] ofs_q;
    logic              ld_sel;

    assign rst = mrst | prst;

    dcff_g2b #(.W(PW)) u_g2b (.gray(rgray_s), .bin(rbin_s));

    always_comb begin
        wcnt           = wbin - rbin_s;
        wnext          = wbin + PW'(1);
        st.full        = (wcnt == FULL_CNT);
        st.almost_full = (wcnt >= (FULL_CNT - {1'b0, af_ofs}));
        st.half_full   = (wcnt > HALF_CNT);
        we             = wen && !ld && !st.full && !rst;
        waddr          = wbin[ADDR_W-1:0];
        ae_ofs         = ofs_q[ADDR_W-1:0];
        af_ofs         = ofs_q[2*ADDR_W-1:ADDR_W];
    end

    // write pointer, binary and Gray kept together
    always_ff @(posedge clk) begin
        if (rst) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (we) begin
            wbin  <= wnext;
            wgray <= wnext ^ (wnext >> 1);
        end
    end

    // thresholds and timing mode: only master reset returns them to defaults
    always_ff @(posedge clk) begin
        if (mrst) begin
            ofs_q  <= dflt_sel ? {HI_V, HI_V} : {LO_V, LO_V};
            mode   <= timing_e'(si);
            ld_sel <= 1'b0;
        end else if (prst) begin
            ld_sel <= 1'b0;
        end else if (ld && sen) begin
            ofs_q <= {si, ofs_q[2*ADDR_W-1:1]};
        end else if (ld && wen) begin
            if (!ld_sel) ofs_q[ADDR_W-1:0]        <= ofs_din;
            else         ofs_q[2*ADDR_W-1:ADDR_W] <= ofs_din;
            ld_sel <= !ld_sel;
        end
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        (wen && !ld && st.full) |=> $stable(wbin));

    assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
        wcnt <= FULL_CNT);

    assert_ofs_hold_R7: assert property (@(posedge clk) disable iff (mrst)
        !ld |=> $stable(ofs_q));

    assert_prst_keeps_R8: assert property (@(posedge clk) disable iff (mrst)
        prst |=> ($stable(mode) && $stable(ofs_q)));
endmodule

// File: rtl/dcff_rd.sv
module dcff_rd
    import dcff_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  timing_e           mode,
    input  logic [ADDR_W-1:0] ae_ofs,
    input  logic              ren,
    input  logic              rt,
    input  logic [ADDR_W:0]   wgray_s,
    input  word_t             mem_q,
    output logic [ADDR_W-1:0] raddr,
    output logic [ADDR_W:0]   rgray,
    output word_t             dout,
    output rd_status_t        st
);
    localparam int PW = ADDR_W + 1;

    logic          fw, ov, mem_has, take, pop_only;
    logic [PW-1:0] rbin, rnext, wbin_s, mcnt, avail;

    dcff_g2b #(.W(PW)) u_g2b (.gray(wgray_s), .bin(wbin_s));

    always_comb begin
        fw              = (mode == TIMING_FWFT);
        mcnt            = wbin_s - rbin;
        mem_has         = (mcnt != '0);
        rnext           = rbin + PW'(1);
        take            = fw ? ((!ov || ren) && mem_has) : (ren && mem_has);
        pop_only        = fw && ren && ov && !mem_has;
        avail           = mcnt + PW'(fw && ov);
        st.empty        = fw ? !ov : !mem_has;
        st.almost_empty = (avail <= {1'b0, ae_ofs});
        raddr           = rbin[ADDR_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rbin  <= '0;
            rgray <= '0;
            ov    <= 1'b0;
            dout  <= '0;
        end else if (rt) begin
            rbin  <= '0;
            rgray <= '0;
            ov    <= 1'b0;
        end else if (take) begin
            rbin  <= rnext;
            rgray <= rnext ^ (rnext >> 1);
            dout  <= mem_q;
            ov    <= fw;
        end else if (pop_only) begin
            ov    <= 1'b0;
        end
    end

    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (rst)
        (!fw && ren && st.empty && !rt) |=> ($stable(rbin) && $stable(dout)));

    assert_fwft_autoload_R10: assert property (@(posedge clk) disable iff (rst)
        (fw && st.empty && mem_has && !rt) |=> !st.empty);

    assert_empty_is_low_R6: assert property (@(posedge clk) disable iff (rst)
        (!fw && st.empty) |-> st.almost_empty);
endmodule

// File: rtl/dcff_top.sv
module dcff_top
    import dcff_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int OFS_LO = 7,
    parameter int OFS_HI = 31
) (
    input  logic        wr_clk,
    input  logic        rd_clk,
    input  logic        mrst,
    input  logic        prst,
    input  logic        si_mode,
    input  logic        dflt_sel,
    input  logic        ld,
    input  logic        sen,
    input  logic        wen,
    input  logic [17:0] din,
    input  logic        ren,
    input  logic        rt,
    input  logic        oe,
    output logic [17:0] dout,
    output logic        dout_drv,
    output logic        rd_empty,
    output logic        wr_full,
    output logic        half_full,
    output logic        almost_empty,
    output logic        almost_full
);
    localparam int PW = ADDR_W + 1;

    logic              any_rst, we;
    logic [ADDR_W-1:0] waddr, raddr, ae_ofs, af_ofs;
    logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s;
    word_t             mem_q, dq;
    wr_status_t        wst;
    rd_status_t        rst_s;
    timing_e           mode;

    assign any_rst = mrst | prst;

    dcff_wr #(.ADDR_W(ADDR_W), .OFS_LO(OFS_LO), .OFS_HI(OFS_HI)) u_wr (
        .clk(wr_clk), .mrst(mrst), .prst(prst), .wen(wen), .ld(ld), .sen(sen),
        .si(si_mode), .dflt_sel(dflt_sel), .ofs_din(din[ADDR_W-1:0]),
        .rgray_s(rgray_s), .we(we), .waddr(waddr), .wgray(wgray), .st(wst),
        .ae_ofs(ae_ofs), .af_ofs(af_ofs), .mode(mode)
    );

    dcff_ram #(.ADDR_W(ADDR_W)) u_ram (
        .wclk(wr_clk), .we(we), .waddr(waddr), .wdata(din),
        .raddr(raddr), .rdata(mem_q)
    );

    dcff_sync #(.W(PW)) u_w2r (.clk(rd_clk), .rst(any_rst), .d(wgray), .q(wgray_s));
    dcff_sync #(.W(PW)) u_r2w (.clk(wr_clk), .rst(any_rst), .d(rgray), .q(rgray_s));

    dcff_rd #(.ADDR_W(ADDR_W)) u_rd (
        .clk(rd_clk), .rst(any_rst), .mode(mode), .ae_ofs(ae_ofs), .ren(ren),
        .rt(rt), .wgray_s(wgray_s), .mem_q(mem_q), .raddr(raddr),
        .rgray(rgray), .dout(dq), .st(rst_s)
    );

    assign dout         = oe ? dq : '0;
    assign dout_drv     = oe;
    assign rd_empty     = rst_s.empty;
    assign almost_empty = rst_s.almost_empty;
    assign wr_full      = wst.full;
    assign half_full    = wst.half_full;
    assign almost_full  = wst.almost_full;
endmodule

// File: tb/tb_dcff_top.sv
`timescale 10ps/10ps
module tb_dcff_top;
    localparam int AW = 4;
    localparam int DEPTH = 1 << AW;
    localparam int LO = 2;
    localparam int HI = 5;

    logic wclk, rclk;
    logic mrst = 1'b1, prst = 1'b0, si = 1'b0, dsel = 1'b0, ld = 1'b0, sen = 1'b0;
    logic wen = 1'b0, ren = 1'b0, rt = 1'b0, oe = 1'b1;
    logic [17:0] din = '0;
    logic [17:0] dout;
    logic dout_drv, rd_empty, wr_full, half_full, almost_empty, almost_full;

    int rhalf = 160;
    int n_run = 0;
    int n_fail = 0;

    dcff_top #(.ADDR_W(AW), .OFS_LO(LO), .OFS_HI(HI)) dut (
        .wr_clk(wclk), .rd_clk(rclk), .mrst(mrst), .prst(prst), .si_mode(si),
        .dflt_sel(dsel), .ld(ld), .sen(sen), .wen(wen), .din(din), .ren(ren),
        .rt(rt), .oe(oe), .dout(dout), .dout_drv(dout_drv), .rd_empty(rd_empty),
        .wr_full(wr_full), .half_full(half_full), .almost_empty(almost_empty),
        .almost_full(almost_full)
    );

    // 200 MHz write clock on even time steps; read clock on odd ones
    initial begin wclk = 1'b0; forever #250 wclk = ~wclk; end
    initial begin rclk = 1'b0; #1; forever #(rhalf) rclk = ~rclk; end

    // {read half period, word count, fall-through}
    localparam int NV = 8;
    localparam logic [24:0] VEC [NV] = '{
        {16'd100,  8'd40, 1'b0}, {16'd100,  8'd40, 1'b1},
        {16'd560,  8'd30, 1'b0}, {16'd560,  8'd30, 1'b1},
        {16'd250,  8'd48, 1'b0}, {16'd124,  8'd60, 1'b1},
        {16'd1210, 8'd20, 1'b0}, {16'd76,   8'd50, 1'b0}
    };

    function automatic logic [17:0] pat(input int i);
        return 18'(i * 2749 + 17);
    endfunction

    task automatic chk_eq(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_mrst(input bit fw, input bit d);
        @(negedge wclk);
        mrst = 1'b1; si = fw; dsel = d; wen = 1'b0; ld = 1'b0; sen = 1'b0;
        ren = 1'b0; rt = 1'b0;
        repeat (3) @(posedge rclk);
        repeat (3) @(negedge wclk);
        mrst = 1'b0; si = 1'b0;
        repeat (2) @(negedge wclk);
    endtask

    task automatic do_prst();
        @(negedge wclk);
        prst = 1'b1; ren = 1'b0;
        repeat (3) @(posedge rclk);
        repeat (3) @(negedge wclk);
        prst = 1'b0;
        repeat (2) @(negedge wclk);
    endtask

    task automatic wr(input logic [17:0] w);
        @(negedge wclk); wen = 1'b1; din = w;
        @(negedge wclk); wen = 1'b0;
    endtask

    task automatic ld_par(input logic [17:0] v);
        @(negedge wclk); ld = 1'b1; wen = 1'b1; din = v;
        @(negedge wclk); ld = 1'b0; wen = 1'b0;
    endtask

    task automatic ld_ser(input logic [2*AW-1:0] bits);
        for (int i = 0; i < 2 * AW; i++) begin
            @(negedge wclk); ld = 1'b1; sen = 1'b1; si = bits[i];
        end
        @(negedge wclk); ld = 1'b0; sen = 1'b0; si = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge rclk);
    endtask

    task automatic wait_ready(output int k);
        k = 0;
        while (rd_empty && k < 40) begin @(negedge rclk); k++; end
    endtask

    task automatic rd_std(input logic [17:0] exp, input string req);
        int k;
        @(negedge rclk);
        wait_ready(k);
        ren = 1'b1;
        @(negedge rclk); ren = 1'b0;
        chk_eq(req, int'(dout), int'(exp));
    endtask

    task automatic pop_fw(input logic [17:0] exp, input string req);
        int k;
        @(negedge rclk);
        wait_ready(k);
        chk_eq(req, int'(dout), int'(exp));
        ren = 1'b1;
        @(negedge rclk); ren = 1'b0;
    endtask

    task automatic stream(input int n, input bit fw, input int base);
        int got = 0;
        fork
            begin
                int i = 0;
                int cyc = 0;
                while (i < n) begin
                    @(negedge wclk);
                    wen = 1'b0;
                    cyc++;
                    if (!wr_full && (cyc % 4) != 3) begin
                        wen = 1'b1; din = pat(base + i); i++;
                    end
                end
                @(negedge wclk); wen = 1'b0;
            end
            begin
                bit pend = 1'b0;
                int guard = 0;
                while (got < n && guard < 20000) begin
                    @(negedge rclk); guard++;
                    if (fw) begin
                        ren = 1'b0;
                        if (!rd_empty) begin
                            chk_eq("R12 fall-through order", int'(dout), int'(pat(base + got)));
                            got++; ren = 1'b1;
                        end
                    end else begin
                        if (pend) begin
                            chk_eq("R12 standard order", int'(dout), int'(pat(base + got)));
                            got++;
                        end
                        ren = !rd_empty && (got < n);
                        pend = ren;
                    end
                end
                @(negedge rclk); ren = 1'b0;
            end
        join
        chk_eq("R12 word count", got, n);
        settle();
        chk_eq("R12 drained", int'(rd_empty), 1);
    endtask

    initial begin
        repeat (150000) @(posedge wclk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got %0d expected %0d", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int k;
        // R1: reset state while held and after release
        repeat (2) @(negedge wclk);
        chk_eq("R1 empty in reset", int'(rd_empty), 1);
        chk_eq("R1 full in reset", int'(wr_full), 0);
        do_mrst(1'b0, 1'b0);
        settle();
        chk_eq("R1 empty", int'(rd_empty), 1);
        chk_eq("R1 full", int'(wr_full), 0);
        chk_eq("R1 half", int'(half_full), 0);
        chk_eq("R1 almost full", int'(almost_full), 0);
        chk_eq("R1 almost empty", int'(almost_empty), 1);

        // R12: vector table over clock ratios and both timings
        for (int v = 0; v < NV; v++) begin
            rhalf = int'(VEC[v][24:9]);
            do_mrst(VEC[v][0], 1'b0);
            stream(int'(VEC[v][8:1]), VEC[v][0], 1000 * (v + 1));
        end
        rhalf = 160;

        // R3 R5 R6: fill with default thresholds (low set)
        do_mrst(1'b0, 1'b0);
        for (int i = 0; i < DEPTH; i++) begin
            wr(pat(i));
            if (i + 1 == DEPTH / 2)     chk_eq("R5 half at half", int'(half_full), 0);
            if (i + 1 == DEPTH / 2 + 1) chk_eq("R5 half above half", int'(half_full), 1);
            if (i + 1 == DEPTH - LO - 1) chk_eq("R6 almost full below", int'(almost_full), 0);
            if (i + 1 == DEPTH - LO)    chk_eq("R6 almost full at", int'(almost_full), 1);
            if (i + 1 == DEPTH - 1)     chk_eq("R3 not yet full", int'(wr_full), 0);
        end
        chk_eq("R3 full at depth", int'(wr_full), 1);
        wr(18'h3FFFF);
        chk_eq("R3 still full", int'(wr_full), 1);
        settle();
        chk_eq("R6 almost empty off", int'(almost_empty), 0);
        for (int i = 0; i < DEPTH; i++) rd_std(pat(i), "R3 R4 data after overflow");
        settle();
        chk_eq("R3 extra word dropped", int'(rd_empty), 1);
        @(negedge rclk); ren = 1'b1;
        @(negedge rclk); ren = 1'b0;
        chk_eq("R4 read while empty", int'(dout), int'(pat(DEPTH - 1)));

        // R2 R6: high default thresholds
        do_mrst(1'b0, 1'b1);
        for (int i = 0; i < 11; i++) begin
            wr(pat(i));
            if (i + 1 == HI) begin settle(); chk_eq("R2 R6 almost empty at hi", int'(almost_empty), 1); end
            if (i + 1 == HI + 1) begin settle(); chk_eq("R2 R6 almost empty above hi", int'(almost_empty), 0); end
            if (i + 1 == DEPTH - HI - 1) chk_eq("R2 almost full below hi", int'(almost_full), 0);
            if (i + 1 == DEPTH - HI) chk_eq("R2 almost full at hi", int'(almost_full), 1);
        end

        // R7: parallel load, empty threshold 3 then full threshold 7
        do_mrst(1'b0, 1'b0);
        ld_par(18'd3);
        ld_par(18'd7);
        settle();
        chk_eq("R7 load stores no data", int'(rd_empty), 1);
        for (int i = 0; i < 9; i++) begin
            wr(pat(i));
            if (i + 1 == 3) begin settle(); chk_eq("R7 parallel empty thr", int'(almost_empty), 1); end
            if (i + 1 == 4) begin settle(); chk_eq("R7 parallel empty thr above", int'(almost_empty), 0); end
            if (i + 1 == 8) chk_eq("R7 parallel full thr below", int'(almost_full), 0);
            if (i + 1 == 9) chk_eq("R7 parallel full thr", int'(almost_full), 1);
        end

        // R8: partial reset keeps thresholds
        do_prst();
        settle();
        chk_eq("R8 empty after partial", int'(rd_empty), 1);
        chk_eq("R8 not full after partial", int'(wr_full), 0);
        chk_eq("R8 no half after partial", int'(half_full), 0);
        for (int i = 0; i < 9; i++) begin
            wr(pat(i));
            if (i + 1 == 3) begin settle(); chk_eq("R8 empty thr kept", int'(almost_empty), 1); end
            if (i + 1 == 4) begin settle(); chk_eq("R8 empty thr kept above", int'(almost_empty), 0); end
            if (i + 1 == 8) chk_eq("R8 full thr kept below", int'(almost_full), 0);
            if (i + 1 == 9) chk_eq("R8 full thr kept", int'(almost_full), 1);
        end

        // R7: serial load, empty threshold 1, full threshold 4
        do_mrst(1'b0, 1'b0);
        ld_ser({4'd4, 4'd1});
        for (int i = 0; i < 12; i++) begin
            wr(pat(i));
            if (i + 1 == 1) begin settle(); chk_eq("R7 serial empty thr", int'(almost_empty), 1); end
            if (i + 1 == 2) begin settle(); chk_eq("R7 serial empty thr above", int'(almost_empty), 0); end
            if (i + 1 == 11) chk_eq("R7 serial full thr below", int'(almost_full), 0);
            if (i + 1 == 12) chk_eq("R7 serial full thr", int'(almost_full), 1);
        end

        // R2: master reset discards the programmed thresholds
        do_mrst(1'b0, 1'b0);
        for (int i = 0; i < DEPTH - LO; i++) begin
            wr(pat(i));
            if (i + 1 == 2) begin settle(); chk_eq("R2 default empty thr back", int'(almost_empty), 1); end
            if (i + 1 == DEPTH - LO - 1) chk_eq("R2 default full thr below", int'(almost_full), 0);
        end
        chk_eq("R2 default full thr back", int'(almost_full), 1);

        // R4 R9: latency and retransmit in standard timing
        do_mrst(1'b0, 1'b0);
        wr(pat(100));
        wait_ready(k);
        chk_eq("R4 first word latency", int'(k <= 4), 1);
        for (int i = 1; i < 5; i++) wr(pat(100 + i));
        for (int i = 0; i < 5; i++) rd_std(pat(100 + i), "R4 standard read");
        @(negedge rclk); rt = 1'b1;
        @(negedge rclk); rt = 1'b0;
        for (int i = 0; i < 5; i++) rd_std(pat(100 + i), "R9 standard replay");

        // R10 R9 R11 R8: fall-through timing
        do_mrst(1'b1, 1'b0);
        wr(pat(200));
        wait_ready(k);
        chk_eq("R10 fall-through latency", int'(k <= 4), 1);
        chk_eq("R10 word shown unrequested", int'(dout), int'(pat(200)));
        wr(pat(201));
        wr(pat(202));
        for (int i = 0; i < 3; i++) pop_fw(pat(200 + i), "R10 fall-through pop");
        settle();
        chk_eq("R10 empty after pops", int'(rd_empty), 1);
        @(negedge rclk); rt = 1'b1;
        @(negedge rclk); rt = 1'b0;
        settle();
        chk_eq("R9 replay ready", int'(rd_empty), 0);
        chk_eq("R9 replay first word", int'(dout), int'(pat(200)));
        @(negedge rclk); oe = 1'b0;
        @(negedge rclk);
        chk_eq("R11 bus zero", int'(dout), 0);
        chk_eq("R11 drive off", int'(dout_drv), 0);
        oe = 1'b1;
        @(negedge rclk);
        chk_eq("R11 word kept", int'(dout), int'(pat(200)));
        chk_eq("R11 drive on", int'(dout_drv), 1);
        do_prst();
        settle();
        chk_eq("R8 fall-through empty", int'(rd_empty), 1);
        wr(pat(300));
        settle();
        chk_eq("R8 mode kept ready", int'(rd_empty), 0);
        chk_eq("R8 mode kept word", int'(dout), int'(pat(300)));

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule